// File: doc/BRIEF.md
# Host Power State Controller

This block watches three status lines coming from the host (a power-good level, an active-low lid-closed line and an active-low host-suspended line) and sorts the host into one of four system states. Each input crosses into the local clock domain through its own synchronizer. Any change of the classified state is reported with a single-cycle event strobe, and the new code is held on the state output. A separate strobe fires on every rising or falling edge of the lid and power-good lines, even when the classified state does not change.

A second layer sets the chip's own activity mode. Stop is the resting mode, with the clock enable low. Wait keeps the clock running for timer users such as a PWM channel or LED blinking. Run is used to process an event for a fixed hold window, and for as long as a host transaction is in progress. When nothing holds the mode up, it drops back to the lowest mode that is still needed.

Top module: `host_power_ctrl`

## Requirements
- R1: The state output reads Critical (code 0) whenever the synchronized power-good level is 0, whatever the lid and suspend lines are.
- R2: With power-good 1 and the lid line 0, the state reads Lid Closed (code 1).
- R3: With power-good 1, the lid line 1 and the host-suspended line 0, the state reads Suspend (code 2).
- R4: With all three inputs at 1, the state reads Host (code 3).
- R5: An input change that alters the classified state drives the state event output high for exactly one cycle. That cycle starts on the third rising clock edge after the change is sampled, and the state output shows the new code from that same edge.
- R6: Every rising or falling edge of power-good or of the lid line gives a one-cycle edge strobe with the same latency as R5, even when the state is unchanged. A change of the suspend line alone never gives an edge strobe.
- R7: After reset is released, the state is taken from the current input levels within SYNC_STAGES+1 cycles, and neither strobe fires for that settling.
- R8: The activity mode output codes are Stop 0, Wait 1 and Run 2. Stop is the default. The clock enable is 0 in Stop and 1 in Wait and Run.
- R9: When any timer request bit is set and nothing requires Run, the mode is Wait from the next cycle on.
- R10: A state event or edge strobe puts the mode in Run from the next cycle, for RUN_HOLD cycles. After that the mode falls back to Wait or Stop.
- R11: While the transaction-busy input is high, the mode is Run from the next cycle on. Run takes priority over Wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok_i | input | 1 | Host power-good level, asynchronous |
| lid_n_i | input | 1 | Lid-closed line, active low, asynchronous |
| hsus_n_i | input | 1 | Host-suspended line, active low, asynchronous |
| timer_req_i | input | NUM_TIMERS | One request bit per timer user that needs a running clock |
| xact_busy_i | input | 1 | High while a host transaction is in progress |
| state_o | output | 2 | Host state code: 0 Critical, 1 Lid Closed, 2 Suspend, 3 Host |
| state_evt_o | output | 1 | One-cycle strobe on a state change |
| edge_irq_o | output | 1 | One-cycle strobe on any edge of power-good or the lid line |
| mode_o | output | 2 | Activity mode: 0 Stop, 1 Wait, 2 Run |
| clk_en_o | output | 1 | Clock enable level, high outside Stop |

## Verification
The bench builds the block with two synchronizer stages, a Run hold of four cycles and two timer request bits. With a short hold, the whole Run window, including the exact cycle it falls back to Stop or Wait, can be checked after every transition. With two timer bits, the bench shows that the upper request bit alone is enough to reach Wait. The default synchronizer depth keeps the three-edge latency of events fixed, so every strobe is sampled in its single expected cycle, and the same latency holds for the edge strobe raised when the lid line changes while power is low.

// File: rtl/hpsc_pkg.sv
package hpsc_pkg;

  typedef enum logic [1:0] {
    HS_CRITICAL = 2'd0,
    HS_LID_SHUT = 2'd1,
    HS_SUSPEND  = 2'd2,
    HS_ACTIVE   = 2'd3
  } host_state_e;

  typedef enum logic [1:0] {
    AM_STOP = 2'd0,
    AM_WAIT = 2'd1,
    AM_RUN  = 2'd2
  } act_mode_e;

  // bit positions of the synchronized status vector
  localparam int unsigned ST_PWR = 0;
  localparam int unsigned ST_LID = 1;
  localparam int unsigned ST_SUS = 2;
  localparam int unsigned ST_W   = 3;

endpackage

// File: rtl/hpsc_sync.sv
module hpsc_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= async_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[LAST];

endmodule

// File: rtl/hpsc_classify.sv
module hpsc_classify
  import hpsc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] status_i,
  output host_state_e     state_o,
  output logic            state_evt_o,
  output logic            edge_irq_o
);

  localparam int unsigned INIT_LAST = SYNC_STAGES + 1;
  localparam int unsigned INIT_W    = $clog2(INIT_LAST + 1);

  logic [INIT_W-1:0] init_cnt_q, init_cnt_d;
  logic              settled;
  host_state_e       state_q, state_d, class_w;
  logic              evt_q, evt_d;
  logic              irq_q, irq_d;
  logic              pwr_prev_q, lid_prev_q;

  assign settled = (init_cnt_q == INIT_W'(INIT_LAST));

  // classification, power-good first, then lid, then suspend
  always_comb begin
    if (!status_i[ST_PWR])      class_w = HS_CRITICAL;
    else if (!status_i[ST_LID]) class_w = HS_LID_SHUT;
    else if (!status_i[ST_SUS]) class_w = HS_SUSPEND;
    else                        class_w = HS_ACTIVE;
  end

  always_comb begin
    init_cnt_d = settled ? init_cnt_q : init_cnt_q + INIT_W'(1);
    state_d    = class_w;
    evt_d      = settled && (class_w != state_q);
    irq_d      = settled && ((status_i[ST_PWR] != pwr_prev_q) ||
                             (status_i[ST_LID] != lid_prev_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_cnt_q <= '0;
      state_q    <= HS_CRITICAL;
      evt_q      <= 1'b0;
      irq_q      <= 1'b0;
      pwr_prev_q <= 1'b0;
      lid_prev_q <= 1'b0;
    end else begin
      init_cnt_q <= init_cnt_d;
      state_q    <= state_d;
      evt_q      <= evt_d;
      irq_q      <= irq_d;
      pwr_prev_q <= status_i[ST_PWR];
      lid_prev_q <= status_i[ST_LID];
    end
  end

  assign state_o     = state_q;
  assign state_evt_o = evt_q;
  assign edge_irq_o  = irq_q;

endmodule

// File: rtl/hpsc_activity.sv
module hpsc_activity
  import hpsc_pkg::*;
#(
  parameter int unsigned NUM_TIMERS = 2,
  parameter int unsigned RUN_HOLD   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wake_pulse_i,
  input  logic                  busy_i,
  input  logic [NUM_TIMERS-1:0] timer_req_i,
  output act_mode_e             mode_o,
  output logic                  clk_en_o
);

  localparam int unsigned HOLD_W = $clog2(RUN_HOLD + 1);

  logic [HOLD_W-1:0] hold_q, hold_d;
  act_mode_e         mode_q, mode_d;
  logic              hold_live;

  assign hold_live = (hold_q != '0);

  always_comb begin
    if (wake_pulse_i)   hold_d = HOLD_W'(RUN_HOLD - 1);
    else if (hold_live) hold_d = hold_q - HOLD_W'(1);
    else                hold_d = hold_q;

    if (wake_pulse_i || hold_live || busy_i) mode_d = AM_RUN;
    else if (|timer_req_i)                   mode_d = AM_WAIT;
    else                                     mode_d = AM_STOP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      mode_q   <= AM_STOP;
      clk_en_o <= 1'b0;
    end else begin
      hold_q   <= hold_d;
      mode_q   <= mode_d;
      clk_en_o <= (mode_d != AM_STOP);
    end
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/host_power_ctrl.sv
module host_power_ctrl
  import hpsc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned NUM_TIMERS  = 2,
  parameter int unsigned RUN_HOLD    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pwr_ok_i,
  input  logic                  lid_n_i,
  input  logic                  hsus_n_i,
  input  logic [NUM_TIMERS-1:0] timer_req_i,
  input  logic                  xact_busy_i,
  output logic [1:0]            state_o,
  output logic                  state_evt_o,
  output logic                  edge_irq_o,
  output logic [1:0]            mode_o,
  output logic                  clk_en_o
);

  logic [ST_W-1:0] raw_w, sync_w;
  host_state_e     state_w;
  act_mode_e       mode_w;
  logic            evt_w, irq_w;

  assign raw_w[ST_PWR] = pwr_ok_i;
  assign raw_w[ST_LID] = lid_n_i;
  assign raw_w[ST_SUS] = hsus_n_i;

  hpsc_sync #(.WIDTH(ST_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_w),
    .sync_o  (sync_w)
  );

  hpsc_classify #(.SYNC_STAGES(SYNC_STAGES)) u_class (
    .clk         (clk),
    .rst_n       (rst_n),
    .status_i    (sync_w),
    .state_o     (state_w),
    .state_evt_o (evt_w),
    .edge_irq_o  (irq_w)
  );

  hpsc_activity #(.NUM_TIMERS(NUM_TIMERS), .RUN_HOLD(RUN_HOLD)) u_act (
    .clk          (clk),
    .rst_n        (rst_n),
    .wake_pulse_i (evt_w | irq_w),
    .busy_i       (xact_busy_i),
    .timer_req_i  (timer_req_i),
    .mode_o       (mode_w),
    .clk_en_o     (clk_en_o)
  );

  assign state_o     = state_w;
  assign state_evt_o = evt_w;
  assign edge_irq_o  = irq_w;
  assign mode_o      = mode_w;

endmodule

// File: rtl/host_power_ctrl_chk.sv
module host_power_ctrl_chk #(
  parameter int unsigned NUM_TIMERS = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  pwr_ok_i,
  input logic [NUM_TIMERS-1:0] timer_req_i,
  input logic                  xact_busy_i,
  input logic [1:0]            state_o,
  input logic                  state_evt_o,
  input logic                  edge_irq_o,
  input logic [1:0]            mode_o,
  input logic                  clk_en_o
);

  logic [3:0] age_q;
  logic       aged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age_q <= '0;
    else if (age_q != 4'd15) age_q <= age_q + 4'd1;
  end
  assign aged = (age_q >= 4'd8);

  // R1: power low three samples ago leaves Critical on the output
  a_r1_critical_on_power_low: assert property (@(posedge clk) disable iff (!rst_n)
    (aged && !$past(pwr_ok_i, 3)) |-> (state_o == 2'd0));

  // R5: an event always comes with a new state code
  a_r5_event_moves_state: assert property (@(posedge clk) disable iff (!rst_n)
    (aged && state_evt_o) |-> (state_o != $past(state_o)));

  // R10: a strobe is followed by Run
  a_r10_strobe_gives_run: assert property (@(posedge clk) disable iff (!rst_n)
    (state_evt_o || edge_irq_o) |=> (mode_o == 2'd2));

  // R11: busy forces Run one cycle later
  a_r11_busy_gives_run: assert property (@(posedge clk) disable iff (!rst_n)
    (aged && $past(xact_busy_i)) |-> (mode_o == 2'd2));

  // R9: a timer request keeps the clock alive
  a_r9_timer_not_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (aged && ($past(timer_req_i) != '0)) |-> (mode_o != 2'd0 && clk_en_o));

  // R8: only defined mode codes, enable tracks mode
  a_r8_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'd3) && (clk_en_o == (mode_o != 2'd0)));

endmodule

bind host_power_ctrl host_power_ctrl_chk #(.NUM_TIMERS(NUM_TIMERS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pwr_ok_i    (pwr_ok_i),
  .timer_req_i (timer_req_i),
  .xact_busy_i (xact_busy_i),
  .state_o     (state_o),
  .state_evt_o (state_evt_o),
  .edge_irq_o  (edge_irq_o),
  .mode_o      (mode_o),
  .clk_en_o    (clk_en_o)
);

// File: tb/host_power_ctrl_test.sv
`timescale 1ns/1ps
module host_power_ctrl_test;

  localparam int unsigned HOLD = 4;
  localparam int unsigned NT   = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pwr_ok = 1'b1, lid_n = 1'b1, hsus_n = 1'b1, busy = 1'b0;
  logic [NT-1:0] treq = '0;
  logic [1:0]    state, mode;
  logic          evt, irq, clk_en;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  host_power_ctrl #(.SYNC_STAGES(2), .NUM_TIMERS(NT), .RUN_HOLD(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_ok_i(pwr_ok), .lid_n_i(lid_n),
    .hsus_n_i(hsus_n), .timer_req_i(treq), .xact_busy_i(busy),
    .state_o(state), .state_evt_o(evt), .edge_irq_o(irq),
    .mode_o(mode), .clk_en_o(clk_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // drive inputs, then follow the strobe and the Run window
  task automatic apply(input logic p, input logic l, input logic h,
                       input int exp_state, input int exp_evt,
                       input int exp_irq, input string req);
    @(negedge clk);
    pwr_ok = p; lid_n = l; hsus_n = h;
    edges(2);
    chk({req, " no early strobe"}, evt | irq, 0);
    edges(1);
    chk({req, " state"}, state, exp_state);
    chk({req, " event"}, evt, exp_evt);
    chk({req, " edge strobe"}, irq, exp_irq);
    edges(1);
    chk({req, " strobe one cycle"}, evt | irq, 0);
    if (exp_evt != 0 || exp_irq != 0) begin
      chk("R10 run after strobe", mode, 2);
      edges(HOLD - 1);
      chk("R10 run held to end", mode, 2);
      edges(1);
      chk("R10 back to stop", mode, 0);
      chk("R8 clock enable low", clk_en, 0);
    end else begin
      chk({req, " ignored mode stays stop"}, mode, 0);
    end
  endtask

  task automatic t_reset;
    #1;
    chk("R8 reset mode", mode, 0);
    chk("R8 reset enable", clk_en, 0);
    chk("R5 reset event", evt, 0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      edges(1);
      chk("R7 no strobe while settling", evt | irq, 0);
    end
    chk("R7 state from levels", state, 3);
    chk("R4 host state", state, 3);
    chk("R8 idle stop", mode, 0);
  endtask

  task automatic t_states;
    apply(1, 1, 0, 2, 1, 0, "R3 suspend");
    apply(1, 0, 0, 1, 1, 1, "R2 lid closed");
    apply(1, 1, 1, 3, 1, 1, "R4 host");
    apply(0, 1, 1, 0, 1, 1, "R1 critical");
    apply(0, 0, 1, 0, 0, 1, "R6 lid edge while critical");
    apply(0, 0, 0, 0, 0, 0, "R6 suspend alone");
    apply(0, 1, 1, 0, 0, 1, "R1 lid rise still critical");
    apply(1, 1, 1, 3, 1, 1, "R6 power rise");
  endtask

  task automatic t_timers;
    @(negedge clk); treq = 2'b10;
    edges(1);
    chk("R9 wait on timer", mode, 1);
    chk("R8 enable in wait", clk_en, 1);
    @(negedge clk); busy = 1'b1;
    edges(1);
    chk("R11 run over wait", mode, 2);
    edges(5);
    chk("R11 run while busy", mode, 2);
    @(negedge clk); busy = 1'b0;
    edges(1);
    chk("R11 back to wait", mode, 1);
    @(negedge clk); treq = '0;
    edges(1);
    chk("R8 back to stop", mode, 0);
    chk("R8 enable off", clk_en, 0);
  endtask

  task automatic t_event_with_timer;
    @(negedge clk); treq = 2'b01;
    edges(1);
    @(negedge clk); hsus_n = 1'b0;
    edges(3);
    chk("R5 event with timer", evt, 1);
    chk("R3 suspend code", state, 2);
    edges(1 + HOLD);
    chk("R10 falls back to wait", mode, 1);
    @(negedge clk); treq = '0; hsus_n = 1'b1;
    edges(3 + HOLD + 1);
    chk("R4 host again", state, 3);
  endtask

  initial begin
    t_reset();
    t_states();
    t_timers();
    t_event_with_timer();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule